// File: doc/BRIEF.md
# Four-Channel I/Q Sample Output Port

This block gathers I/Q sample pairs from four receive channels and sends them out over a single 16-bit parallel port, pacing each word with a request/acknowledge handshake on the port clock. Each channel has a one-deep holding register. A newer sample from a channel replaces an unsent one from that same channel and never touches any other channel. When more than one channel is waiting, a fixed priority picks the next channel: the lowest channel index wins.

The port enable and a per-channel select mask decide which channels may use the port. One format bit picks between two formats. In interleaved format a sample goes out as two full-width words, I first and then Q. In packed format a sample goes out as one word made of the upper byte of I and the upper byte of Q. Alongside every word the port drives a binary source-channel number and an I/Q indicator.

A state machine moves a sample through four states. `ST_IDLE` means nothing is presented. `ST_SEND_I` presents the interleaved I word. `ST_SEND_Q` presents the interleaved Q word. `ST_SEND_PK` presents a packed word. A channel is chosen, and its sample is copied into a shadow register, only at a "take" point. A take point is any cycle spent in `ST_IDLE`, or the cycle in which the last word of a sample is accepted. At a take point the transitions are:
- `ST_IDLE`→`ST_SEND_I`/`ST_SEND_PK` (capture)
- `ST_SEND_I`→`ST_SEND_Q` (I accepted)
- `ST_SEND_Q`/`ST_SEND_PK`→`ST_SEND_I`/`ST_SEND_PK` (accepted, another channel waiting)
- `ST_SEND_Q`/`ST_SEND_PK`→`ST_IDLE` (accepted, nothing waiting)

Top module: `iq_pp_port`

## Requirements
- R1: A word is accepted only on a rising clock edge where `pp_req` and `pp_ack` are both high. While `pp_req` is high and `pp_ack` is low, `pp_data`, `pp_chan` and `pp_iq` hold their values.
- R2: In interleaved format (`fmt_packed`=0), a sample is sent as two words: the full I word with `pp_iq`=1, then the full Q word with `pp_iq`=0 and the same channel number.
- R3: In packed format (`fmt_packed`=1), a sample is sent as one word: bits [15:8] carry I[15:8], bits [7:0] carry Q[15:8], and `pp_iq`=1.
- R4: In packed format, if another channel is waiting when a word is accepted, the next word is presented on the very next cycle. `pp_req` and `pp_iq` stay high across the whole burst.
- R5: `pp_chan` carries the binary index (0 to 3) of the channel that supplied the word being presented.
- R6: Each channel keeps only its newest unsent sample. A newer sample replaces only that same channel's register.
- R7: At each take point, the waiting enabled channel with the lowest index is chosen.
- R8: Once an interleaved I word is presented, the matching Q word follows it. No higher-priority arrival and no gap in `pp_ack` can change this.
- R9: A sample that arrives on the same edge its channel's register is captured becomes that channel's new waiting sample.
- R10: A channel is enabled only when `port_en` is 1 and its bit in `chan_sel` is 1. A disabled channel discards incoming samples, drops any waiting sample, and never causes a request.
- R11: After reset, `pp_req`=0, `pp_iq`=0, `pp_chan`=0 and `pp_data`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| port_en | input | 1 | Enable for the whole port |
| chan_sel | input | 4 | Per-channel output select mask |
| fmt_packed | input | 1 | 1 = packed 8I/8Q format, 0 = interleaved 16-bit format |
| smp_vld | input | 4 | New-sample strobe, one bit per channel |
| smp_i | input | 64 | I samples, channel c in bits [16c+15:16c] |
| smp_q | input | 64 | Q samples, channel c in bits [16c+15:16c] |
| pp_ack | input | 1 | Receiver acknowledge |
| pp_req | output | 1 | A word is being presented |
| pp_data | output | 16 | Port data word |
| pp_chan | output | 2 | Source channel of the presented word |
| pp_iq | output | 1 | I/Q indicator |

## Verification
The bench drives samples into several channels on the same edge and checks that they leave in index order. A design with the priority reversed, or one that picks the winner while a word is in flight, would send channels out of order. Some directed cases hold `pp_ack` low in the middle of an interleaved pair while a higher-priority sample arrives; a design that re-arbitrates there would split the pair, or mark the Q word with the wrong channel number. Other directed cases send a sample on the same edge its channel is captured, overwrite an unsent sample, and disable channels that have a sample waiting. A design that clears the pending flag after the load would lose the new sample, and one that ignores the mask would raise a request it should not. Random traffic with changing formats and masks checks each packed burst, where a design that drops to idle between samples would let `pp_iq` fall inside the burst.

// File: rtl/iq_pp_pkg.sv
package iq_pp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SEND_I  = 2'd1,
        ST_SEND_Q  = 2'd2,
        ST_SEND_PK = 2'd3
    } pp_state_t;

endpackage

// File: rtl/iq_pp_hold.sv
// One-deep holding register for a single channel.
// A load wins over a drain on the same edge, so the new sample survives (R9).
module iq_pp_hold #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         in_vld,
    input  logic [W-1:0] in_i,
    input  logic [W-1:0] in_q,
    input  logic         drain,
    output logic         pend,
    output logic [W-1:0] out_i,
    output logic [W-1:0] out_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend  <= 1'b0;
            out_i <= '0;
            out_q <= '0;
        end else if (in_vld && en) begin
            pend  <= 1'b1;
            out_i <= in_i;
            out_q <= in_q;
        end else if (!en || drain) begin
            pend  <= 1'b0;
        end
    end

endmodule

// File: rtl/iq_pp_arb.sv
// Fixed-priority selector: the lowest index wins.
module iq_pp_arb #(
    parameter int  NCH = 4,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic [NCH-1:0] req,
    output logic           any,
    output logic [CHW-1:0] idx,
    output logic [NCH-1:0] grant
);

    always_comb begin
        any   = 1'b0;
        idx   = '0;
        grant = '0;
        for (int k = NCH - 1; k >= 0; k--) begin
            if (req[k]) begin
                any   = 1'b1;
                idx   = CHW'(k);
                grant = NCH'(1) << k;
            end
        end
    end

endmodule

// File: rtl/iq_pp_fsm.sv
// Port sequencer: captures a winner at take points and presents its words.
module iq_pp_fsm
    import iq_pp_pkg::*;
#(
    parameter int W   = 16,
    parameter int CHW = 2,
    localparam int HW = W / 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           fmt_packed,
    input  logic           ack,
    input  logic           any,
    input  logic [CHW-1:0] win_idx,
    input  logic [W-1:0]   win_i,
    input  logic [W-1:0]   win_q,
    output logic           cap,
    output pp_state_t      st,
    output logic           req,
    output logic [W-1:0]   data,
    output logic [CHW-1:0] chan,
    output logic           iq
);

    pp_state_t      st_d;
    logic [W-1:0]   sh_i;
    logic [W-1:0]   sh_q;
    logic [CHW-1:0] sh_ch;
    logic           xfer;
    logic           take;
    pp_state_t      first_st;

    assign xfer     = (st != ST_IDLE) && ack;
    assign take     = (st == ST_IDLE) || (xfer && (st == ST_SEND_Q || st == ST_SEND_PK));
    assign cap      = take && any;
    assign first_st = fmt_packed ? ST_SEND_PK : ST_SEND_I;

    always_comb begin
        st_d = st;
        unique case (st)
            ST_IDLE:    if (any) st_d = first_st;
            ST_SEND_I:  if (ack) st_d = ST_SEND_Q;
            ST_SEND_Q:  if (ack) st_d = any ? first_st : ST_IDLE;
            ST_SEND_PK: if (ack) st_d = any ? first_st : ST_IDLE;
            default:    st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= ST_IDLE;
        end else begin
            st <= st_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_i  <= '0;
            sh_q  <= '0;
            sh_ch <= '0;
        end else if (cap) begin
            sh_i  <= win_i;
            sh_q  <= win_q;
            sh_ch <= win_idx;
        end
    end

    always_comb begin
        req  = 1'b1;
        data = '0;
        chan = sh_ch;
        iq   = 1'b0;
        unique case (st)
            ST_IDLE: begin
                req  = 1'b0;
                chan = '0;
            end
            ST_SEND_I: begin
                data = sh_i;
                iq   = 1'b1;
            end
            ST_SEND_Q: begin
                data = sh_q;
            end
            ST_SEND_PK: begin
                data = {sh_i[W-1:HW], sh_q[W-1:HW]};
                iq   = 1'b1;
            end
            default: req = 1'b0;
        endcase
    end

endmodule

// File: rtl/iq_pp_port.sv
// Multi-channel I/Q parallel output port (top).
module iq_pp_port
    import iq_pp_pkg::*;
#(
    parameter int  NCH = 4,
    parameter int  W   = 16,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             port_en,
    input  logic [NCH-1:0]   chan_sel,
    input  logic             fmt_packed,
    input  logic [NCH-1:0]   smp_vld,
    input  logic [NCH*W-1:0] smp_i,
    input  logic [NCH*W-1:0] smp_q,
    input  logic             pp_ack,
    output logic             pp_req,
    output logic [W-1:0]     pp_data,
    output logic [CHW-1:0]   pp_chan,
    output logic             pp_iq
);

    logic [NCH-1:0] en;
    logic [NCH-1:0] pend;
    logic [NCH-1:0] elig;
    logic [NCH-1:0] grant;
    logic [NCH-1:0] drain;
    logic [W-1:0]   hold_i [NCH];
    logic [W-1:0]   hold_q [NCH];
    logic           any;
    logic [CHW-1:0] win_idx;
    logic           cap;
    pp_state_t      st;

    assign en    = {NCH{port_en}} & chan_sel;
    assign elig  = pend & en;
    assign drain = cap ? grant : '0;

    for (genvar c = 0; c < NCH; c++) begin : g_hold
        iq_pp_hold #(.W(W)) u_hold (
            .clk    (clk),
            .rst_n  (rst_n),
            .en     (en[c]),
            .in_vld (smp_vld[c]),
            .in_i   (smp_i[c*W +: W]),
            .in_q   (smp_q[c*W +: W]),
            .drain  (drain[c]),
            .pend   (pend[c]),
            .out_i  (hold_i[c]),
            .out_q  (hold_q[c])
        );
    end

    iq_pp_arb #(.NCH(NCH)) u_arb (
        .req   (elig),
        .any   (any),
        .idx   (win_idx),
        .grant (grant)
    );

    iq_pp_fsm #(.W(W), .CHW(CHW)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .fmt_packed (fmt_packed),
        .ack        (pp_ack),
        .any        (any),
        .win_idx    (win_idx),
        .win_i      (hold_i[win_idx]),
        .win_q      (hold_q[win_idx]),
        .cap        (cap),
        .st         (st),
        .req        (pp_req),
        .data       (pp_data),
        .chan       (pp_chan),
        .iq         (pp_iq)
    );

endmodule

// File: rtl/iq_pp_port_chk.sv
module iq_pp_port_chk
    import iq_pp_pkg::*;
#(
    parameter int  NCH = 4,
    parameter int  W   = 16,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input logic           clk,
    input logic           rst_n,
    input logic           port_en,
    input logic           pp_ack,
    input logic           pp_req,
    input logic [W-1:0]   pp_data,
    input logic [CHW-1:0] pp_chan,
    input logic           pp_iq,
    input pp_state_t      st,
    input logic           cap,
    input logic [CHW-1:0] cap_ch,
    input logic [NCH-1:0] elig
);

    logic [NCH-1:0] below;
    always_comb begin
        for (int k = 0; k < NCH; k++) below[k] = (k < int'(cap_ch));
    end

    p_hold_stable_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (pp_req && !pp_ack) |=> (pp_req && $stable(pp_data) && $stable(pp_chan) && $stable(pp_iq)));

    p_i_then_q_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SEND_I && pp_ack) |=> (st == ST_SEND_Q && !pp_iq && pp_chan == $past(pp_chan)));

    p_packed_iq_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SEND_PK) |-> (pp_iq && pp_req));

    p_burst_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SEND_PK && pp_ack && elig != '0) |=> (pp_req && pp_iq));

    p_priority_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cap |-> (elig[cap_ch] && (elig & below) == '0));

    p_pair_whole_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SEND_I) |=> (st == ST_SEND_I || st == ST_SEND_Q));

    p_disabled_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && !port_en) |=> !pp_req);

endmodule

bind iq_pp_port iq_pp_port_chk #(.NCH(NCH), .W(W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .port_en (port_en),
    .pp_ack  (pp_ack),
    .pp_req  (pp_req),
    .pp_data (pp_data),
    .pp_chan (pp_chan),
    .pp_iq   (pp_iq),
    .st      (st),
    .cap     (cap),
    .cap_ch  (win_idx),
    .elig    (elig)
);

// File: tb/iq_pp_port_tb_top.sv
`timescale 1ns/1ps
module iq_pp_port_tb_top;

    localparam int NCH = 4;
    localparam int W   = 16;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           port_en = 1'b0;
    logic [NCH-1:0] chan_sel = '0;
    logic           fmt_packed = 1'b0;
    logic [NCH-1:0] smp_vld = '0;
    logic [W-1:0]   bi [NCH];
    logic [W-1:0]   bq [NCH];
    logic [NCH*W-1:0] smp_i;
    logic [NCH*W-1:0] smp_q;
    logic           pp_ack = 1'b0;
    logic           pp_req;
    logic [W-1:0]   pp_data;
    logic [1:0]     pp_chan;
    logic           pp_iq;

    int    n_chk = 0;
    int    n_err = 0;
    bit    done  = 0;
    string tag   = "R11";

    always #10 clk = ~clk;

    always_comb begin
        for (int c = 0; c < NCH; c++) begin
            smp_i[c*W +: W] = bi[c];
            smp_q[c*W +: W] = bq[c];
        end
    end

    iq_pp_port #(.NCH(NCH), .W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .port_en(port_en), .chan_sel(chan_sel),
        .fmt_packed(fmt_packed), .smp_vld(smp_vld), .smp_i(smp_i), .smp_q(smp_q),
        .pp_ack(pp_ack), .pp_req(pp_req), .pp_data(pp_data), .pp_chan(pp_chan), .pp_iq(pp_iq)
    );

    // Reference model built from the requirements: 0 idle, 1 I word, 2 Q word, 3 packed.
    int         m_st = 0;
    bit         m_pend [NCH];
    logic [W-1:0] m_i [NCH];
    logic [W-1:0] m_q [NCH];
    logic [W-1:0] m_si = '0, m_sq = '0;
    int         m_ch = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 0; m_ch = 0; m_si = '0; m_sq = '0;
            for (int c = 0; c < NCH; c++) begin m_pend[c] = 0; m_i[c] = '0; m_q[c] = '0; end
        end else begin
            bit xfer, take;
            int win;
            xfer = (m_st != 0) && pp_ack;
            take = (m_st == 0) || (xfer && (m_st == 2 || m_st == 3));
            win = -1;
            for (int c = NCH - 1; c >= 0; c--)
                if (m_pend[c] && port_en && chan_sel[c]) win = c;
            if (take) begin
                if (win >= 0) begin
                    m_si = m_i[win]; m_sq = m_q[win]; m_ch = win;
                    m_st = fmt_packed ? 3 : 1;
                end else m_st = 0;
            end else if (xfer && m_st == 1) m_st = 2;
            for (int c = 0; c < NCH; c++) begin
                bit en_c;
                en_c = port_en && chan_sel[c];
                if (smp_vld[c] && en_c) begin m_pend[c] = 1; m_i[c] = bi[c]; m_q[c] = bq[c]; end
                else if (!en_c) m_pend[c] = 0;
                else if (take && win == c) m_pend[c] = 0;
            end
        end
    end

    function automatic logic [W-1:0] exp_data(int st, logic [W-1:0] si, logic [W-1:0] sq);
        case (st)
            1: return si;
            2: return sq;
            3: return {si[W-1:W/2], sq[W-1:W/2]};
            default: return '0;
        endcase
    endfunction

    task automatic chk(string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        chk("req", int'(pp_req), int'(m_st != 0));
        chk("iq", int'(pp_iq), int'(m_st == 1 || m_st == 3));
        chk("chan", int'(pp_chan), (m_st != 0) ? m_ch : 0);
        chk("data", int'(pp_data), int'(exp_data(m_st, m_si, m_sq)));
    endtask

    task automatic send(logic [NCH-1:0] v);
        for (int c = 0; c < NCH; c++) begin
            bi[c] = W'($urandom);
            bq[c] = W'($urandom);
        end
        smp_vld = v;
        tick();
        smp_vld = '0;
    endtask

    task automatic idle_wait(int n);
        for (int k = 0; k < n; k++) tick();
    endtask

    initial begin
        for (int c = 0; c < NCH; c++) begin bi[c] = '0; bq[c] = '0; end
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        tag = "R11";
        tick();
        rst_n = 1'b1;
        tick();
        port_en = 1'b1; chan_sel = '1; pp_ack = 1'b1;

        tag = "R2"; fmt_packed = 1'b0;
        send(4'b0010); idle_wait(4);

        tag = "R5"; send(4'b1000); idle_wait(4);

        tag = "R7"; fmt_packed = 1'b1;
        send(4'b1011); idle_wait(6);

        tag = "R3"; send(4'b0100); idle_wait(3);

        tag = "R4"; send(4'b1111); send(4'b0011); idle_wait(8);

        tag = "R6"; pp_ack = 1'b0;
        send(4'b0001); send(4'b1000); send(4'b1000); idle_wait(2);
        pp_ack = 1'b1; idle_wait(5);

        tag = "R8"; fmt_packed = 1'b0; pp_ack = 1'b0;
        send(4'b1000); idle_wait(1);
        send(4'b0001); idle_wait(1);
        pp_ack = 1'b1; tick(); pp_ack = 1'b0; idle_wait(2);
        pp_ack = 1'b1; idle_wait(6);

        tag = "R9"; send(4'b0100); send(4'b0100); idle_wait(6);

        tag = "R1"; pp_ack = 1'b0; send(4'b0010); idle_wait(4);
        pp_ack = 1'b1; idle_wait(4);

        tag = "R10"; chan_sel = 4'b1101;
        send(4'b0010); idle_wait(4);
        pp_ack = 1'b0; send(4'b0101); chan_sel = 4'b0000; idle_wait(2);
        pp_ack = 1'b1; idle_wait(4);
        chan_sel = '1; port_en = 1'b0; send(4'b1111); idle_wait(4);
        port_en = 1'b1;

        tag = "R1";
        for (int n = 0; n < 4000; n++) begin
            if ($urandom_range(0, 149) == 0) fmt_packed = ~fmt_packed;
            if ($urandom_range(0, 199) == 0) chan_sel = NCH'($urandom);
            if ($urandom_range(0, 299) == 0) chan_sel = '1;
            if ($urandom_range(0, 399) == 0) port_en = ~port_en;
            if ($urandom_range(0, 99) == 0) port_en = 1'b1;
            pp_ack = ($urandom_range(0, 9) < 7);
            send(NCH'($urandom) & NCH'($urandom));
        end

        done = 1;
        $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL R1 watchdog: actual still running expected finished");
            $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule